// File: doc/BRIEF.md
# Bus cycle termination decoder

This block sits in a bus master next to the cycle sequencer and decides how each asynchronous bus cycle ends. It takes three active-low termination inputs from outside the chip: a transfer acknowledge, a bus error and a halt request. The inputs are sampled at the even-numbered states of the cycle while address strobe is asserted. The block combines what it sees at one sampling state and at the next sampling state into one of four outcomes. A cycle can complete normally, complete and then freeze the master, end with a bus error exception, or end and be rerun later.

The outcome is reported as a one-cycle pulse with a two-bit kind code. Alongside it come a bus error request pulse and a pending-exception flag, which the core clears when it accepts the exception. A stall output keeps the sequencer idle while the master is halted or waiting to retry. When a retry is released, a one-cycle retry request is issued, and the captured cycle address is still there for the reissued cycle. Two diagnostic pulses cover misbehaving external logic: termination inputs that are still asserted into the next cycle, and inputs released in the wrong order.

Top module: `bus_term_decoder`

## Requirements
- R1: After reset all outputs are low and `cyc_addr` is zero. Each termination input passes through a two-stage synchronizer, so a decision reflects the input level driven two clocks before the sampling state. The decision pulse appears one clock after that state.
- R2: With acknowledge seen at sampling state N, no bus error at N or N+2, and halt negated at N, the cycle ends with kind 0 (normal), decided at N+2.
- R3: With acknowledge and halt seen at N and no bus error at N+2, the cycle ends with kind 1 (halt), decided at N+2. `halted` and `stall` then stay high until the synchronized halt input is negated.
- R4: Bus error with halt negated, at N (with or without acknowledge) or at N+2 after acknowledge, ends the cycle with kind 2. It also pulses `berr_req` and sets `exc_pending`, which stays high until `exc_ack` is asserted.
- R5: Bus error and halt together end the cycle with kind 3 (retry). This holds when they come before or with acknowledge, and when they come at N+2 after an acknowledge. `stall` stays high until halt is negated, and then `retry_req` pulses for one clock.
- R6: A sampling state with neither acknowledge nor bus error inserts a wait state. Halt alone does not end a cycle, and no termination is issued however long this lasts.
- R7: Inputs are evaluated only at nonzero even values of `bus_state` while `as_active` is high. After a termination nothing is evaluated again until `as_active` has fallen.
- R8: `cyc_addr` loads `addr_i` on the rising edge of `as_active`, but only while `stall` is low. It keeps its value for the whole stall, so a retry reissues the same address.
- R9: If acknowledge or bus error has stayed asserted since the previous termination and is still asserted at state 2 of the next cycle, `proto_err` pulses once.
- R10: `order_err` pulses when bus error is released while acknowledge is still asserted, or when halt is released while bus error is still asserted. Simultaneous release is legal.
- R11: `term_valid` is a single-clock pulse and occurs at most once per bus cycle. The kind codes are 0 normal, 1 halt, 2 bus error and 3 retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| berr_n | input | 1 | Bus error, active low, asynchronous |
| halt_n | input | 1 | Halt request, active low, asynchronous |
| as_active | input | 1 | Address strobe asserted for the current cycle |
| bus_state | input | STATE_W | Current bus state number from the sequencer |
| addr_i | input | ADDR_W | Address and transfer attributes of the cycle |
| exc_ack | input | 1 | Core accepts the pending bus error exception |
| term_valid | output | 1 | One-clock termination pulse |
| term_kind | output | 2 | Termination kind, valid with term_valid |
| berr_req | output | 1 | One-clock bus error exception request |
| exc_pending | output | 1 | Bus error exception not yet accepted |
| halted | output | 1 | Master frozen after a halt termination |
| stall | output | 1 | Sequencer must stay idle (halted or waiting to retry) |
| retry_req | output | 1 | One-clock request to rerun the last cycle |
| proto_err | output | 1 | Termination input carried into the next cycle |
| order_err | output | 1 | Termination inputs released in the wrong order |
| cyc_addr | output | ADDR_W | Captured cycle address, held across a stall |

## Verification
The bench aims at the two-sample cases. An acknowledge followed at the next sampling state by bus error, or by bus error with halt, has to turn into a bus error or a retry. A decoder that decides at the first acknowledge reports normal instead, and one that ignores priority reports a bus error where a retry belongs. It drives acknowledge pulses only at odd states and while address strobe is low, and a decoder that samples too eagerly terminates a cycle spuriously. It also raises address strobe during a retry stall, which a loose address latch would follow, and it leaves acknowledge asserted into the next cycle and releases bus error ahead of acknowledge or halt ahead of bus error, where a wrong monitor stays silent or flags a legal simultaneous release.

// File: rtl/bterm_pkg.sv
package bterm_pkg;

  typedef enum logic [1:0] {
    TK_NORMAL = 2'd0,
    TK_HALT   = 2'd1,
    TK_BERR   = 2'd2,
    TK_RETRY  = 2'd3
  } term_kind_e;

  typedef enum logic [2:0] {
    ST_WATCH  = 3'd0,
    ST_ACKD   = 3'd1,
    ST_DONE   = 3'd2,
    ST_HALTW  = 3'd3,
    ST_RETRYW = 3'd4
  } seq_state_e;

  localparam int TERM_INPUTS = 3;

endpackage

// File: rtl/bterm_sync.sv
module bterm_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/bterm_fsm.sv
module bterm_fsm
  import bterm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       ack_a,
  input  logic       berr_a,
  input  logic       halt_a,
  input  logic       as_active,
  input  logic       exc_ack,
  output logic       term_valid,
  output term_kind_e term_kind,
  output logic       berr_req,
  output logic       exc_pending,
  output logic       halted,
  output logic       stall,
  output logic       retry_req
);

  seq_state_e st_q, st_d;
  logic       hn_q, hn_d;
  logic       term_d, berr_d, retry_d, exc_d;
  term_kind_e kind_d;
  logic       err_any, err_retry;

  // Bus error decides alone; paired with halt it becomes a retry.
  assign err_any   = berr_a;
  assign err_retry = berr_a & halt_a;

  always_comb begin
    st_d    = st_q;
    hn_d    = hn_q;
    term_d  = 1'b0;
    kind_d  = TK_NORMAL;
    retry_d = 1'b0;
    case (st_q)
      ST_WATCH: begin
        if (smp_en) begin
          if (err_retry) begin
            term_d = 1'b1; kind_d = TK_RETRY; st_d = ST_RETRYW;
          end else if (err_any) begin
            term_d = 1'b1; kind_d = TK_BERR;  st_d = ST_DONE;
          end else if (ack_a) begin
            st_d = ST_ACKD; hn_d = halt_a;
          end
        end
      end
      ST_ACKD: begin
        if (smp_en) begin
          term_d = 1'b1;
          if (err_retry) begin
            kind_d = TK_RETRY; st_d = ST_RETRYW;
          end else if (err_any) begin
            kind_d = TK_BERR;  st_d = ST_DONE;
          end else if (hn_q) begin
            kind_d = TK_HALT;  st_d = ST_HALTW;
          end else begin
            kind_d = TK_NORMAL; st_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (!as_active) st_d = ST_WATCH;
      end
      ST_HALTW: begin
        if (!halt_a) st_d = ST_DONE;
      end
      ST_RETRYW: begin
        if (!halt_a) begin
          st_d = ST_DONE; retry_d = 1'b1;
        end
      end
      default: st_d = ST_WATCH;
    endcase
    berr_d = term_d & (kind_d == TK_BERR);
    exc_d  = berr_d | (exc_pending & ~exc_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_WATCH;
      hn_q        <= 1'b0;
      term_valid  <= 1'b0;
      term_kind   <= TK_NORMAL;
      berr_req    <= 1'b0;
      exc_pending <= 1'b0;
      retry_req   <= 1'b0;
    end else begin
      st_q        <= st_d;
      hn_q        <= hn_d;
      term_valid  <= term_d;
      term_kind   <= kind_d;
      berr_req    <= berr_d;
      exc_pending <= exc_d;
      retry_req   <= retry_d;
    end
  end

  assign halted = (st_q == ST_HALTW);
  assign stall  = (st_q == ST_HALTW) | (st_q == ST_RETRYW);

endmodule

// File: rtl/bterm_mon.sv
module bterm_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_a,
  input  logic berr_a,
  input  logic halt_a,
  input  logic term_valid,
  input  logic first_smp,
  output logic proto_err,
  output logic order_err
);

  logic [2:0] prv_q;
  logic       carry_q, carry_d;
  logic       proto_d, order_d;
  logic       berr_early, halt_early;

  assign berr_early = prv_q[1] & ~berr_a & ack_a;
  assign halt_early = prv_q[0] & ~halt_a & berr_a;

  always_comb begin
    order_d = berr_early | halt_early;
    proto_d = first_smp & carry_q & (ack_a | berr_a);
    carry_d = carry_q;
    if (term_valid)            carry_d = 1'b1;
    else if (!ack_a && !berr_a) carry_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q     <= 3'b000;
      carry_q   <= 1'b0;
      proto_err <= 1'b0;
      order_err <= 1'b0;
    end else begin
      prv_q     <= {ack_a, berr_a, halt_a};
      carry_q   <= carry_d;
      proto_err <= proto_d;
      order_err <= order_d;
    end
  end

endmodule

// File: rtl/bus_term_decoder.sv
module bus_term_decoder
  import bterm_pkg::*;
#(
  parameter int STATE_W     = 4,
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_n,
  input  logic               berr_n,
  input  logic               halt_n,
  input  logic               as_active,
  input  logic [STATE_W-1:0] bus_state,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               exc_ack,
  output logic               term_valid,
  output logic [1:0]         term_kind,
  output logic               berr_req,
  output logic               exc_pending,
  output logic               halted,
  output logic               stall,
  output logic               retry_req,
  output logic               proto_err,
  output logic               order_err,
  output logic [ADDR_W-1:0]  cyc_addr
);

  localparam logic [STATE_W-1:0] FIRST_SMP_STATE = STATE_W'(2);

  logic [TERM_INPUTS-1:0] raw_n, syn_n;
  logic       ack_a, berr_a, halt_a;
  logic       smp_en, first_smp;
  logic       as_q, addr_en;
  term_kind_e kind_w;
  logic       term_w;

  assign raw_n = {ack_n, berr_n, halt_n};

  bterm_sync #(
    .W      (TERM_INPUTS),
    .STAGES (SYNC_STAGES),
    .RST_VAL({TERM_INPUTS{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_n),
    .q    (syn_n)
  );

  assign {ack_a, berr_a, halt_a} = ~syn_n;

  assign smp_en    = as_active & ~bus_state[0] & (|bus_state);
  assign first_smp = smp_en & (bus_state == FIRST_SMP_STATE);

  bterm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .ack_a      (ack_a),
    .berr_a     (berr_a),
    .halt_a     (halt_a),
    .as_active  (as_active),
    .exc_ack    (exc_ack),
    .term_valid (term_w),
    .term_kind  (kind_w),
    .berr_req   (berr_req),
    .exc_pending(exc_pending),
    .halted     (halted),
    .stall      (stall),
    .retry_req  (retry_req)
  );

  bterm_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_a     (ack_a),
    .berr_a    (berr_a),
    .halt_a    (halt_a),
    .term_valid(term_w),
    .first_smp (first_smp),
    .proto_err (proto_err),
    .order_err (order_err)
  );

  assign term_valid = term_w;
  assign term_kind  = kind_w;

  // Capture on a fresh strobe only while the master is free to start a cycle.
  assign addr_en = as_active & ~as_q & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q     <= 1'b0;
      cyc_addr <= '0;
    end else begin
      as_q <= as_active;
      if (addr_en) cyc_addr <= addr_i;
    end
  end

endmodule

// File: rtl/bus_term_decoder_chk.sv
module bus_term_decoder_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_active,
  input logic              state_lsb,
  input logic              term_valid,
  input logic [1:0]        term_kind,
  input logic              berr_req,
  input logic              exc_pending,
  input logic              stall,
  input logic              retry_req,
  input logic [ADDR_W-1:0] cyc_addr
);

  // R11
  term_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |=> !term_valid);

  // R4
  berr_req_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_req |-> (term_valid && term_kind == 2'd2));

  // R4
  exc_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_pending) |-> berr_req);

  // R5
  retry_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> (!stall && $past(stall)));

  // R3
  stall_starts_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> term_valid);

  // R7
  term_from_even_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> ($past(as_active) && !$past(state_lsb)));

  // R8
  addr_held_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> $stable(cyc_addr));

endmodule

bind bus_term_decoder bus_term_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .as_active  (as_active),
  .state_lsb  (bus_state[0]),
  .term_valid (term_valid),
  .term_kind  (term_kind),
  .berr_req   (berr_req),
  .exc_pending(exc_pending),
  .stall      (stall),
  .retry_req  (retry_req),
  .cyc_addr   (cyc_addr)
);

// File: tb/bus_term_decoder_bench.sv
module bus_term_decoder_bench;

  localparam int STATE_W = 4;
  localparam int ADDR_W  = 24;
  localparam int MAXL    = 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               ack_n, berr_n, halt_n, as_active, exc_ack;
  logic [STATE_W-1:0] bus_state;
  logic [ADDR_W-1:0]  addr_i;
  logic               term_valid, berr_req, exc_pending, halted, stall;
  logic               retry_req, proto_err, order_err;
  logic [1:0]         term_kind;
  logic [ADDR_W-1:0]  cyc_addr;

  always #4 clk = ~clk;

  bus_term_decoder #(.STATE_W(STATE_W), .ADDR_W(ADDR_W)) u_bus_term_decoder (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n),
    .as_active(as_active), .bus_state(bus_state), .addr_i(addr_i), .exc_ack(exc_ack),
    .term_valid(term_valid), .term_kind(term_kind), .berr_req(berr_req),
    .exc_pending(exc_pending), .halted(halted), .stall(stall), .retry_req(retry_req),
    .proto_err(proto_err), .order_err(order_err), .cyc_addr(cyc_addr)
  );

  // Plan arrays: vector bits are [2]=ack, [1]=bus error, [0]=halt (1 = asserted).
  logic [STATE_W-1:0] pst   [MAXL];
  logic               pas   [MAXL];
  logic [2:0]         pv    [MAXL];
  logic [ADDR_W-1:0]  paddr [MAXL];
  int                 plen;
  logic [ADDR_W-1:0]  exp_addr;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  bit  carry = 1'b0;
  logic [2:0] last_vec = 3'b000;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic build(input int w, input logic [2:0] bg, input logic [2:0] f,
                       input logic [2:0] s, input logic [2:0] tailv);
    int n;
    n = 2 * w + 2;
    plen = n + 19;
    for (int i = 0; i < plen; i++) begin
      paddr[i] = ADDR_W'($urandom);
      if (i == 0) begin
        pst[i] = '0; pas[i] = 1'b0; pv[i] = bg;
      end else if (i <= n + 7) begin
        pst[i] = STATE_W'(i); pas[i] = 1'b1;
        pv[i]  = (i < n) ? bg : ((i < n + 2) ? f : s);
      end else if (i <= n + 10) begin
        pst[i] = '0; pas[i] = 1'b0; pv[i] = s;
      end else begin
        pst[i] = '0; pas[i] = 1'b0; pv[i] = tailv;
      end
    end
    exp_addr = paddr[1];
  endtask

  // Reference model of the requirements over the planned sequence.
  task automatic model(output int e_cnt, output int e_kind, output int e_step,
                       output int e_order, output int e_proto);
    int  st, tt, k;
    bit  hn, a, b, h;
    logic [2:0] pr, v;
    st = 0; tt = -1; hn = 1'b0; pr = last_vec;
    e_cnt = 0; e_kind = -1; e_step = -1; e_order = 0; e_proto = 0;
    for (int t = 0; t < plen; t++) begin
      v = pv[t]; a = v[2]; b = v[1]; h = v[0]; k = -1;
      if ((pr[1] && !b && a) || (pr[0] && !h && b)) e_order++;
      pr = v;
      if (pas[t] && pst[t] == 2 && carry && (a || b)) e_proto++;
      if (pas[t] && !pst[t][0] && pst[t] != 0 && st != 2) begin
        if (b && h) k = 3;
        else if (b) k = 2;
        else if (st == 1) k = hn ? 1 : 0;
        else if (a) begin st = 1; hn = h; end
        if (k >= 0) begin
          st = 2; e_cnt++; e_kind = k; e_step = t + 1; tt = t;
        end
      end
      if (tt >= 0 && t == tt + 1) carry = 1'b1;
      else if (!a && !b) carry = 1'b0;
    end
    last_vec = pv[plen-1];
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic play_and_check(input string label);
    int o_cnt, o_kind, o_step, o_stall, o_halted, o_retry, o_order, o_proto;
    int e_cnt, e_kind, e_step, e_order, e_proto, idx, vidx;
    string tg;
    model(e_cnt, e_kind, e_step, e_order, e_proto);
    o_cnt = 0; o_kind = -1; o_step = -1; o_stall = 0; o_halted = 0;
    o_retry = 0; o_order = 0; o_proto = 0;
    for (int t = 0; t < plen + 4; t++) begin
      @(negedge clk);
      if (term_valid) begin
        o_cnt++; o_kind = int'(term_kind); o_step = t;
        o_stall = int'(stall); o_halted = int'(halted);
      end
      if (retry_req) o_retry++;
      if (order_err) o_order++;
      if (proto_err) o_proto++;
      idx  = (t < plen) ? t : plen - 1;
      vidx = (t + 2 < plen) ? t + 2 : plen - 1;
      bus_state = pst[idx];
      as_active = pas[idx];
      addr_i    = paddr[idx];
      {ack_n, berr_n, halt_n} = ~pv[vidx];
    end
    tg = kind_tag(e_kind);
    chk(o_cnt == e_cnt, "R11", {label, " termination count"}, o_cnt, e_cnt);
    if (e_cnt == 1) begin
      chk(o_kind == e_kind, tg, {label, " kind"}, o_kind, e_kind);
      chk(o_step == e_step, "R1", {label, " decision timing"}, o_step, e_step);
      chk(o_stall == int'(e_kind == 1 || e_kind == 3), tg, {label, " stall at term"},
          o_stall, int'(e_kind == 1 || e_kind == 3));
      chk(o_halted == int'(e_kind == 1), "R3", {label, " halted at term"},
          o_halted, int'(e_kind == 1));
    end
    chk(o_retry == int'(e_kind == 3), "R5", {label, " retry pulses"}, o_retry,
        int'(e_kind == 3));
    chk(o_order == e_order, "R10", {label, " order pulses"}, o_order, e_order);
    chk(o_proto == e_proto, "R9", {label, " carry-over pulses"}, o_proto, e_proto);
    chk(cyc_addr == exp_addr, "R8", {label, " captured address"},
        int'(cyc_addr), int'(exp_addr));
    chk(stall == 1'b0, "R3", {label, " stall released"}, int'(stall), 0);
    chk(exc_pending == (e_kind == 2), "R4", {label, " exception pending"},
        int'(exc_pending), int'(e_kind == 2));
    exc_ack = 1'b1;
    @(negedge clk);
    exc_ack = 1'b0;
    @(negedge clk);
    chk(exc_pending == 1'b0, "R4", {label, " exception cleared"}, int'(exc_pending), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] f, s;
    int w;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; ack_n = 1'b1; berr_n = 1'b1; halt_n = 1'b1;
    as_active = 1'b0; exc_ack = 1'b0; bus_state = '0; addr_i = '0;
    repeat (4) @(negedge clk);
    chk({term_valid, berr_req, exc_pending, halted, stall, retry_req, proto_err, order_err} == 8'd0,
        "R1", "reset outputs", 0, 0);
    chk(cyc_addr == '0 && term_kind == 2'd0, "R1", "reset address and kind",
        int'(cyc_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: each table row
    build(0, 3'b000, 3'b100, 3'b100, 3'b000); play_and_check("R2 ack only");
    build(1, 3'b000, 3'b101, 3'b101, 3'b000); play_and_check("R3 ack with halt");
    build(0, 3'b000, 3'b010, 3'b010, 3'b000); play_and_check("R4 berr alone");
    build(0, 3'b000, 3'b100, 3'b110, 3'b000); play_and_check("R4 berr after ack");
    build(0, 3'b000, 3'b011, 3'b111, 3'b000); play_and_check("R5 retry before ack");
    build(0, 3'b000, 3'b100, 3'b111, 3'b000); play_and_check("R5 retry after ack");
    build(2, 3'b000, 3'b001, 3'b001, 3'b000); play_and_check("R6 halt only waits");

    // R7: ack at an odd state and while strobe is low must be ignored
    build(1, 3'b000, 3'b000, 3'b000, 3'b000);
    pv[3] = 3'b100;
    pst[12] = STATE_W'(2); pv[12] = 3'b100;
    play_and_check("R7 odd and strobe-low ack");

    // R8: strobe raised during a retry stall must not reload the address
    build(0, 3'b000, 3'b011, 3'b011, 3'b000);
    pst[11] = STATE_W'(1); pas[11] = 1'b1; paddr[11] = ~exp_addr;
    play_and_check("R8 strobe during stall");

    // R9: ack carried from one cycle into state 2 of the next
    build(0, 3'b000, 3'b100, 3'b100, 3'b100); play_and_check("R9 carry source");
    build(0, 3'b100, 3'b100, 3'b100, 3'b000); play_and_check("R9 carry into next");

    // R10: bus error released before ack, halt released before bus error
    build(0, 3'b000, 3'b110, 3'b100, 3'b000); play_and_check("R10 berr before ack");
    build(0, 3'b000, 3'b011, 3'b010, 3'b000); play_and_check("R10 halt before berr");

    // Constrained random mix
    for (int n = 0; n < 80; n++) begin
      w = int'($urandom % 3);
      f = 3'($urandom);
      s = ($urandom % 4 == 0) ? f : 3'($urandom);
      build(w, 3'b000, f, s, 3'b000);
      play_and_check("random");
    end
    finish_run();
  end

endmodule